// File: doc/BRIEF.md
# Facility Data Link Receive Byte Capture

This block sits behind a T1 framer's receive path. It collects the data link bits that the framer recovers, one bit per strobe, into bytes for a host microcontroller. A bit arrives roughly every 250 microseconds, so a byte completes about every 2 ms. The host has until the following byte completes to read the current one.

An optional zero destuffer can be switched on. It removes the zero that a LAPD-style transmitter inserts after five ones in a row. That inserted zero keeps user data from looking like a flag (01111110) or an abort (11111111). A removed zero does not count toward the byte. Each completed byte is stored in a holding register and compared against two host-programmed patterns. This lets the host ignore the link until a byte of interest appears.

Three sticky status flags report on the byte stream: byte ready, pattern hit and overrun. An active-low interrupt is driven from the first two through individual masks. A one-cycle read strobe from the host acknowledges the byte and clears the flags.

Top module: `fdl_rx_capture`

## Requirements
- R1: After reset, `rx_byte` is 0x00, `st_ready`, `st_hit` and `st_ovr` are 0, and `irq_n` is 1.
- R2: Accepted bits are assembled first-bit-in-LSB. After the eighth accepted bit, `rx_byte[0]` holds the first bit and `rx_byte[7]` the eighth. `rx_byte` updates on the same clock edge that samples the eighth bit.
- R3: `st_ready` sets on the clock edge that completes a byte. It stays set until a read strobe is taken.
- R4: `st_hit` sets when a completed byte equals `pat_a` or `pat_b`. A completed byte that equals neither leaves `st_hit` unchanged. `st_hit` is sticky until read.
- R5: If a byte completes while `st_ready` is set and no read strobe is taken on that edge, `st_ovr` sets and `rx_byte` is replaced by the new byte.
- R6: A read strobe clears all three flags on the next edge. If a byte completes on the same edge as the read, `st_ready` stays set and `st_ovr` stays clear.
- R7: With `destuff_en` at 1, a zero received after five or more consecutive ones is discarded. It does not count toward the byte.
- R8: With `destuff_en` at 0, every strobed bit is accepted, including zeros that follow five ones.
- R9: `irq_n` is 0 exactly when (`st_ready` and `irq_en_ready`) or (`st_hit` and `irq_en_hit`).
- R10: While `bit_vld` is 0, no input other than `rd_stb` changes `rx_byte` or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | Strobe: one data link bit present this cycle |
| bit_in | input | 1 | Data link bit |
| destuff_en | input | 1 | Enable removal of stuffed zeros |
| pat_a | input | 8 | First match pattern |
| pat_b | input | 8 | Second match pattern |
| irq_en_ready | input | 1 | Interrupt mask for byte-ready flag |
| irq_en_hit | input | 1 | Interrupt mask for pattern-hit flag |
| rd_stb | input | 1 | Host read acknowledge, one cycle |
| rx_byte | output | 8 | Last completed byte |
| st_ready | output | 1 | Byte-ready flag (sticky) |
| st_hit | output | 1 | Pattern-hit flag (sticky) |
| st_ovr | output | 1 | Overrun flag (sticky) |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assembler is tried with asymmetric bytes such as 0xA5 and 0x42, which would come out differently if the bit order were reversed. One byte matches the first pattern and another byte matches neither, so a comparator tied to only one pattern or always hitting is exposed. A nine-bit stream of five ones, a zero and three ones is sent twice: with destuffing it must yield 0xFF, and without it 0xDF. Comparing the two results separates a dropped zero from an accepted one. Back-to-back unread bytes, a read on the completing edge, idle gaps and cleared masks tell apart the overrun, read-priority, hold and interrupt-gating paths.

// File: rtl/fdl_pkg.sv
package fdl_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] fdl_byte_t;
endpackage

// File: rtl/fdl_destuff.sv
module fdl_destuff #(
  parameter int unsigned RUN_LIMIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  input  logic destuff_en,
  output logic accept,
  output logic run_at_limit
);
  localparam int unsigned RUN_W = $clog2(RUN_LIMIT + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LIMIT);

  logic [RUN_W-1:0] run_q, run_d;

  assign run_at_limit = (run_q == RUN_MAX);

  always_comb begin
    run_d = run_q;
    if (bit_vld) begin
      if (!bit_in)           run_d = '0;
      else if (!run_at_limit) run_d = run_q + RUN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= '0;
    else if (bit_vld) run_q <= run_d;
  end

  assign accept = bit_vld & ~(destuff_en & ~bit_in & run_at_limit);
endmodule

// File: rtl/fdl_shift.sv
module fdl_shift
  import fdl_pkg::*;
#(
  parameter bit LSB_FIRST = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      acc_en,
  input  logic      acc_bit,
  output logic      byte_done,
  output fdl_byte_t byte_next,
  output logic [$clog2(BYTE_W)-1:0] fill
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  fdl_byte_t        sr_q, sr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  generate
    if (LSB_FIRST) begin : g_lsb
      assign byte_next = {acc_bit, sr_q[BYTE_W-1:1]};
    end else begin : g_msb
      assign byte_next = {sr_q[BYTE_W-2:0], acc_bit};
    end
  endgenerate

  assign byte_done = acc_en & (cnt_q == CNT_LAST);
  assign fill      = cnt_q;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (acc_en) begin
      sr_d  = byte_done ? '0 : byte_next;
      cnt_d = byte_done ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (acc_en) begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/fdl_status.sv
module fdl_status
  import fdl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      byte_done,
  input  fdl_byte_t byte_in,
  input  fdl_byte_t pat_a,
  input  fdl_byte_t pat_b,
  input  logic      rd_stb,
  input  logic      irq_en_ready,
  input  logic      irq_en_hit,
  output fdl_byte_t hold_byte,
  output logic      st_ready,
  output logic      st_hit,
  output logic      st_ovr,
  output logic      irq_n
);
  fdl_byte_t hold_d;
  logic      ready_d, hit_d, ovr_d, pat_eq;

  assign pat_eq = (byte_in == pat_a) | (byte_in == pat_b);

  always_comb begin
    hold_d  = byte_done ? byte_in : hold_byte;
    ready_d = byte_done | (st_ready & ~rd_stb);
    hit_d   = (byte_done & pat_eq) | (st_hit & ~rd_stb);
    ovr_d   = ~rd_stb & (st_ovr | (byte_done & st_ready));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_byte <= '0;
      st_ready  <= 1'b0;
      st_hit    <= 1'b0;
      st_ovr    <= 1'b0;
    end else begin
      hold_byte <= hold_d;
      st_ready  <= ready_d;
      st_hit    <= hit_d;
      st_ovr    <= ovr_d;
    end
  end

  assign irq_n = ~((st_ready & irq_en_ready) | (st_hit & irq_en_hit));

  a_r3_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    st_ready && !rd_stb |=> st_ready);
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && !byte_done |=> !st_ready && !st_hit && !st_ovr);
  a_r5_ovr_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_ovr) |-> $past(st_ready));
  a_r4_hit_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_hit) |-> $past(byte_done));
endmodule

// File: rtl/fdl_rx_capture.sv
module fdl_rx_capture
  import fdl_pkg::*;
#(
  parameter int unsigned RUN_LIMIT = 5,
  parameter bit          LSB_FIRST = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_vld,
  input  logic        bit_in,
  input  logic        destuff_en,
  input  logic [7:0]  pat_a,
  input  logic [7:0]  pat_b,
  input  logic        irq_en_ready,
  input  logic        irq_en_hit,
  input  logic        rd_stb,
  output logic [7:0]  rx_byte,
  output logic        st_ready,
  output logic        st_hit,
  output logic        st_ovr,
  output logic        irq_n
);
  logic accept, run_lim, byte_done;
  fdl_byte_t byte_next;
  logic [$clog2(BYTE_W)-1:0] fill;

  fdl_destuff #(.RUN_LIMIT(RUN_LIMIT)) u_destuff (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .destuff_en(destuff_en), .accept(accept), .run_at_limit(run_lim)
  );

  fdl_shift #(.LSB_FIRST(LSB_FIRST)) u_shift (
    .clk(clk), .rst_n(rst_n), .acc_en(accept), .acc_bit(bit_in),
    .byte_done(byte_done), .byte_next(byte_next), .fill(fill)
  );

  fdl_status u_status (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .byte_in(byte_next),
    .pat_a(pat_a), .pat_b(pat_b), .rd_stb(rd_stb),
    .irq_en_ready(irq_en_ready), .irq_en_hit(irq_en_hit),
    .hold_byte(rx_byte), .st_ready(st_ready), .st_hit(st_hit),
    .st_ovr(st_ovr), .irq_n(irq_n)
  );

  a_r7_stuffed_zero_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld && destuff_en && !bit_in && run_lim |=> $stable(fill));
  a_r8_all_bits_counted: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld && !destuff_en && (fill != '1) |=> fill == $past(fill) + 1'b1);
  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> $stable(fill) && $stable(rx_byte));
endmodule

// File: tb/fdl_rx_capture_tb.sv
module fdl_rx_capture_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_vld = 1'b0, bit_in = 1'b0, destuff_en = 1'b0, rd_stb = 1'b0;
  logic [7:0] pat_a = 8'hA5, pat_b = 8'h7E;
  logic irq_en_ready = 1'b1, irq_en_hit = 1'b1;
  logic [7:0] rx_byte;
  logic st_ready, st_hit, st_ovr, irq_n;

  int checks = 0, fails = 0, cycles = 0;
  bit cmp_on = 1'b0;

  always #10 clk = ~clk;

  fdl_rx_capture u_dut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .destuff_en(destuff_en), .pat_a(pat_a), .pat_b(pat_b),
    .irq_en_ready(irq_en_ready), .irq_en_hit(irq_en_hit), .rd_stb(rd_stb),
    .rx_byte(rx_byte), .st_ready(st_ready), .st_hit(st_hit),
    .st_ovr(st_ovr), .irq_n(irq_n)
  );

  // behavioural reference
  int m_ones, m_nbits;
  int m_acc [$];
  logic [7:0] m_hold;
  bit m_ready, m_hit, m_ovr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ones = 0; m_acc.delete(); m_hold = 8'h00;
      m_ready = 0; m_hit = 0; m_ovr = 0;
    end else begin
      bit take, fin;
      logic [7:0] nb;
      take = bit_vld && !(destuff_en && !bit_in && m_ones >= 5);
      if (bit_vld) m_ones = bit_in ? m_ones + 1 : 0;
      fin = 0;
      if (take) begin
        m_acc.push_back(int'(bit_in));
        if (m_acc.size() == 8) begin
          fin = 1;
          for (int i = 0; i < 8; i++) nb[i] = m_acc[i][0];
          m_acc.delete();
        end
      end
      if (rd_stb) begin m_ovr = 0; m_hit = 0; m_ready = 0; end
      if (fin) begin
        if (m_ready_before_read(rd_stb)) m_ovr = 1;
        m_hold = nb;
        m_ready = 1;
        if (nb == pat_a || nb == pat_b) m_hit = 1;
      end
      m_prev_ready = m_ready;
    end
  end

  bit m_prev_ready = 0;
  function automatic bit m_ready_before_read(input bit rd);
    return m_prev_ready && !rd;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && cmp_on) begin
    chk(rx_byte == m_hold, "R2 rx_byte model", rx_byte, m_hold);
    chk(st_ready == m_ready, "R3 st_ready model", st_ready, m_ready);
    chk(st_hit == m_hit, "R4 st_hit model", st_hit, m_hit);
    chk(st_ovr == m_ovr, "R5 st_ovr model", st_ovr, m_ovr);
    chk(irq_n == !((m_ready && irq_en_ready) || (m_hit && irq_en_hit)),
        "R9 irq_n model", irq_n, !((m_ready && irq_en_ready) || (m_hit && irq_en_hit)));
  end

  task automatic send_bit(input bit b, input bit rd);
    @(negedge clk); bit_vld = 1; bit_in = b; rd_stb = rd;
    @(posedge clk); #2; bit_vld = 0; rd_stb = 0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i], 0);
  endtask

  task automatic do_read();
    @(negedge clk); rd_stb = 1;
    @(posedge clk); #2; rd_stb = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  logic [7:0] snap;
  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(rx_byte == 8'h00, "R1 rx_byte reset", rx_byte, 0);
    chk({st_ready, st_hit, st_ovr} == 3'b000, "R1 flags reset", {st_ready, st_hit, st_ovr}, 0);
    chk(irq_n == 1'b1, "R1 irq_n reset", irq_n, 1);
    rst_n = 1; cmp_on = 1;

    // R2 R4 R9: matching byte, LSB first
    send_byte(8'hA5); @(negedge clk);
    chk(rx_byte == 8'hA5, "R2 byte order", rx_byte, 8'hA5);
    chk(st_hit, "R4 hit on pat_a", st_hit, 1);
    chk(!irq_n, "R9 irq asserted", irq_n, 0);
    do_read(); @(negedge clk);
    chk({st_ready, st_hit, st_ovr} == 3'b000, "R6 read clears", {st_ready, st_hit, st_ovr}, 0);

    // R4 no match, R5 overrun
    send_byte(8'h3C); @(negedge clk);
    chk(st_ready && !st_hit, "R4 no hit on 3C", {st_ready, st_hit}, 2'b10);
    send_byte(8'h42); @(negedge clk);
    chk(st_ovr, "R5 overrun set", st_ovr, 1);
    chk(rx_byte == 8'h42, "R5 byte replaced", rx_byte, 8'h42);
    do_read();

    // R9 masks cleared
    send_byte(8'h7E); @(negedge clk);
    chk(st_hit, "R4 hit on pat_b", st_hit, 1);
    irq_en_ready = 0; irq_en_hit = 0; @(negedge clk);
    chk(irq_n, "R9 masked irq", irq_n, 1);
    irq_en_hit = 1; @(negedge clk);
    chk(!irq_n, "R9 hit mask only", irq_n, 0);
    irq_en_ready = 1;
    do_read();

    // R7 destuffing: 11111 0 111 -> FF
    destuff_en = 1;
    for (int i = 0; i < 5; i++) send_bit(1, 0);
    send_bit(0, 0);
    for (int i = 0; i < 3; i++) send_bit(1, 0);
    @(negedge clk);
    chk(rx_byte == 8'hFF && st_ready, "R7 stuffed zero dropped", rx_byte, 8'hFF);
    do_read();

    // R8 no destuffing: same stream -> DF, one bit left over
    destuff_en = 0;
    for (int i = 0; i < 5; i++) send_bit(1, 0);
    send_bit(0, 0);
    for (int i = 0; i < 3; i++) send_bit(1, 0);
    @(negedge clk);
    chk(rx_byte == 8'hDF, "R8 zero kept", rx_byte, 8'hDF);

    // R10 idle
    snap = rx_byte;
    pat_a = 8'hDF; destuff_en = 1;
    repeat (10) @(negedge clk);
    chk(rx_byte == snap && st_ready && !st_hit, "R10 idle hold", rx_byte, snap);
    pat_a = 8'hA5; destuff_en = 0;

    // R6 read on completing edge: leftover 1 + seven zeros -> 01
    for (int i = 0; i < 6; i++) send_bit(0, 0);
    send_bit(0, 1); @(negedge clk);
    chk(rx_byte == 8'h01, "R6 byte on read edge", rx_byte, 8'h01);
    chk(st_ready && !st_ovr, "R6 completion beats read", {st_ready, st_ovr}, 2'b10);
    do_read();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule